// File: doc/BRIEF.md
# Implication Sequence Checker

This block watches a handful of sampled signals and judges, every clock, a temporal implication between two patterns. The antecedent pattern is "lead, then end after a delay of ANT_LO to ANT_HI cycles". Each completed antecedent starts an attempt of the consequent pattern, which is "lead, then end exactly CON_GAP cycles later". The start comes in the same cycle when NON_OVERLAP is 0, or one cycle later when it is 1. While an attempt is running, a hold condition must stay high. A kill input throws away everything in flight. The verdict leaves through one register, `prop_ok`.

Each pattern is a nondeterministic automaton with one flop per node. A node's flop is set by a clocked edge from the node before it. Any number of attempts can be in progress at once, each sitting in a different node. The named node kinds are: the start node, whose state is its flop ORed with the trigger; the head node, reached through a link when the lead signal is high; the delay nodes, reached through clocked edges; and the accept node, reached through a link when the end signal is high. A link passes state to its target within the same cycle. A clocked edge passes it to the target at the next clock. In the antecedent, delay nodes beyond ANT_LO carry an extra bypass link as well as the edge. That is how the delay range is formed.

MODE picks the verdict. In check mode, `prop_ok` falls for one cycle when the consequent automaton had an active node, carries nothing into the next cycle, and did not reach its accept node. In cover mode, `prop_ok` rises for one cycle after each consequent match, and the implication acts as a plain concatenation of the two patterns.

Top module: `seqchk_implication`

## Requirements
- R1: While rst_n is low, prop_ok is 1 in check mode and 0 in cover mode, and every node flop is clear, so no attempt survives a reset.
- R2: An antecedent completes in cycle t when ante_lead was high in some cycle s with ANT_LO <= t-s <= ANT_HI, ante_end is high in cycle t, and kill is low in every cycle from s to t.
- R3: With NON_OVERLAP=1, a consequent attempt starts in cycle t+1 for an antecedent that completes in cycle t. With NON_OVERLAP=0, it starts in cycle t. Without a completed antecedent, no attempt starts.
- R4: A consequent attempt started in cycle T matches when cons_lead is high in T, cons_end is high in T+CON_GAP, and hold is high in every cycle from T to T+CON_GAP.
- R5: In check mode, prop_ok is 0 in cycle u+1 exactly when, in cycle u, a consequent attempt was starting or under way, no consequent node flop is set for cycle u+1, and no consequent match occurred in u. Otherwise prop_ok is 1.
- R6: Attempts that overlap in time are tracked together in the same node flops. The R5 verdict is taken over the merged state, so an attempt that dies while another is still under way does not pull prop_ok low.
- R7: A cycle with kill high discards every antecedent and consequent attempt, including those that would start in that cycle. In check mode, prop_ok is 1 in the following cycle.
- R8: A cycle with hold low ends every consequent attempt that has not matched by then. An attempt still in its delay nodes at that point produces the R5 failure.
- R9: In cover mode, prop_ok is 1 in cycle u+1 exactly when a consequent match occurred in cycle u.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| kill | input | 1 | Disable condition; discards all attempts in this cycle |
| hold | input | 1 | Condition that must stay high across a consequent attempt (ignored when USE_HOLD=0) |
| ante_lead | input | 1 | First signal of the antecedent pattern |
| ante_end | input | 1 | Closing signal of the antecedent pattern |
| cons_lead | input | 1 | First signal of the consequent pattern |
| cons_end | input | 1 | Closing signal of the consequent pattern |
| prop_ok | output | 1 | Registered verdict: pass/fail in check mode, match seen in cover mode |

## Verification
The verdict for the inputs of cycle u appears on prop_ok after the edge that ends cycle u. A consequent match therefore shows CON_GAP cycles after its lead, plus that one edge. With the default non-overlapped implication, the trigger adds one more cycle after the antecedent end. The bench drives each cycle's inputs at the falling edge and reads both outputs one time unit after the next rising edge. It compares them against a thread-by-thread model that recomputes, from the recorded input history, which attempts started and which are still alive. A hand-worked table pins down the range bounds, the kill and hold cases and a missing consequent lead at the same sampling point.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

    // Verdict flavour of the checker
    typedef enum logic {
        CHK_ASSERT = 1'b0,   // prop_ok low flags a failed implication
        CHK_COVER  = 1'b1    // prop_ok high flags a consequent match
    } chk_mode_e;

endpackage

// File: rtl/seqchk_window.sv
// One pattern "head ##[LEAD_MIN:LEAD_MAX] tail" as a one-flop-per-node
// nondeterministic automaton. Node 0 is the start/head node; node k is
// reached after k clocked edges. Nodes past LEAD_MIN also take a bypass
// link from the node before them, forming the delay range.
module seqchk_window #(
    parameter int LEAD_MIN = 1,
    parameter int LEAD_MAX = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic trig,
    input  logic head,
    input  logic tail,
    input  logic hold,
    output logic match,
    output logic live_now,
    output logic live_next
);

    localparam int DEPTH = LEAD_MAX;

    logic [DEPTH:0] node_q;   // node flops; bit 0 is the start node
    logic [DEPTH:0] node_d;
    logic [DEPTH:0] eff;      // effective node state after links

    // Effective states: flops masked by kill, then links settled in order
    always_comb begin
        eff[0] = (node_q[0] | trig) & ~kill & head & hold;
        for (int k = 1; k <= DEPTH; k++) begin
            eff[k] = (node_q[k] & ~kill) |
                     ((k > LEAD_MIN) && eff[k-1] && hold);
        end
    end

    // Clocked edges: node k-1 -> node k under the hold condition
    always_comb begin
        node_d[0] = 1'b0;
        for (int k = 1; k <= DEPTH; k++) begin
            node_d[k] = eff[k-1] & hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            node_q <= '0;
        end else begin
            node_q <= node_d;
        end
    end

    assign match     = eff[DEPTH] & tail & hold;
    assign live_now  = ((node_q[0] | trig) & ~kill) | (|eff);
    assign live_next = |node_d;

    AST_KILL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (node_q == '0)); // R7

    AST_HOLD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (node_q == '0)); // R8

    AST_MATCH_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> live_now); // R2

endmodule

// File: rtl/seqchk_verdict.sv
// Final verdict register: failure rule in check mode, match flag in
// cover mode.
module seqchk_verdict
    import seqchk_pkg::*;
#(
    parameter chk_mode_e MODE = CHK_ASSERT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live_now,
    input  logic live_next,
    input  logic match,
    output logic prop_ok
);

    localparam logic OK_INIT = (MODE == CHK_COVER) ? 1'b0 : 1'b1;

    logic ok_d;
    logic ok_q;

    always_comb begin
        unique case (MODE)
            CHK_ASSERT: ok_d = ~(live_now & ~live_next & ~match);
            CHK_COVER:  ok_d = match;
            default:    ok_d = OK_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q <= OK_INIT;
        end else begin
            ok_q <= ok_d;
        end
    end

    assign prop_ok = ok_q;

    generate
        if (MODE == CHK_ASSERT) begin : g_chk_props
            AST_IDLE_OK: assert property (@(posedge clk) disable iff (!rst_n)
                !live_now |=> prop_ok); // R5
            AST_MATCH_OK: assert property (@(posedge clk) disable iff (!rst_n)
                match |=> prop_ok); // R5
        end else begin : g_cov_props
            AST_COVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !match |=> !prop_ok); // R9
        end
    endgenerate

endmodule

// File: rtl/seqchk_implication.sv
// Implication checker: antecedent range pattern triggers a fixed-gap
// consequent pattern; registered verdict.
module seqchk_implication
    import seqchk_pkg::*;
#(
    parameter int        ANT_LO      = 1,
    parameter int        ANT_HI      = 3,
    parameter int        CON_GAP     = 2,
    parameter bit        NON_OVERLAP = 1'b1,
    parameter bit        USE_HOLD    = 1'b1,
    parameter chk_mode_e MODE        = CHK_ASSERT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic hold,
    input  logic ante_lead,
    input  logic ante_end,
    input  logic cons_lead,
    input  logic cons_end,
    output logic prop_ok
);

    logic ante_match;
    logic ante_live_now;
    logic ante_live_next;
    logic cons_trig;
    logic hold_g;
    logic cons_match;
    logic cons_live_now;
    logic cons_live_next;

    // Antecedent: start node permanently triggered
    seqchk_window #(
        .LEAD_MIN (ANT_LO),
        .LEAD_MAX (ANT_HI)
    ) u_ante (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (kill),
        .trig      (1'b1),
        .head      (ante_lead),
        .tail      (ante_end),
        .hold      (1'b1),
        .match     (ante_match),
        .live_now  (ante_live_now),
        .live_next (ante_live_next)
    );

    generate
        if (USE_HOLD) begin : g_hold
            assign hold_g = hold;
        end else begin : g_no_hold
            assign hold_g = 1'b1;
        end
    endgenerate

    // Implication joint: one extra clocked node, or a direct link
    generate
        if (NON_OVERLAP) begin : g_next_cycle
            logic join_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    join_q <= 1'b0;
                end else begin
                    join_q <= ante_match;
                end
            end
            assign cons_trig = join_q & ~kill;

            AST_TRIG_AFTER_ANTE: assert property (@(posedge clk) disable iff (!rst_n)
                cons_trig |-> $past(ante_match)); // R3
        end else begin : g_same_cycle
            assign cons_trig = ante_match;
        end
    endgenerate

    // Consequent: fixed gap, started by the antecedent accept
    seqchk_window #(
        .LEAD_MIN (CON_GAP),
        .LEAD_MAX (CON_GAP)
    ) u_cons (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (kill),
        .trig      (cons_trig),
        .head      (cons_lead),
        .tail      (cons_end),
        .hold      (hold_g),
        .match     (cons_match),
        .live_now  (cons_live_now),
        .live_next (cons_live_next)
    );

    seqchk_verdict #(
        .MODE (MODE)
    ) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_now  (cons_live_now),
        .live_next (cons_live_next),
        .match     (cons_match),
        .prop_ok   (prop_ok)
    );

    AST_ANTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ante_live_now && !ante_live_next) |-> !ante_match); // R2

    generate
        if (MODE == CHK_ASSERT) begin : g_kill_prop
            AST_KILL_OK: assert property (@(posedge clk) disable iff (!rst_n)
                kill |=> prop_ok); // R7
        end
    endgenerate

endmodule

// File: tb/seqchk_implication_test.sv
module seqchk_implication_test;
    import seqchk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AL    = 1;
    localparam int AH    = 3;
    localparam int GAP   = 2;
    localparam bit NOVL  = 1'b1;
    localparam int HMAX  = 4096;
    localparam int NRAND = 2500;
    localparam int NVEC  = 26;

    // {kill, hold, ante_lead, ante_end, cons_lead, cons_end, exp_chk, exp_cov}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b01100010,  //  0 R2 antecedent lead
        8'b01000010,  //  1
        8'b01010010,  //  2 R2 end at offset 2
        8'b01001010,  //  3 R3 consequent starts one cycle later
        8'b01000010,  //  4 R4 attempt in delay node
        8'b01000111,  //  5 R4 R9 consequent match
        8'b01110010,  //  6 R2 offset 0 not in range
        8'b01010010,  //  7 R2 offset 1
        8'b01000000,  //  8 R5 consequent lead missing
        8'b01100010,  //  9
        8'b01010010,  // 10
        8'b11001010,  // 11 R7 kill drops trigger
        8'b01100010,  // 12
        8'b01010010,  // 13
        8'b01001010,  // 14
        8'b00000000,  // 15 R8 hold low ends attempt
        8'b01000010,  // 16
        8'b01000010,  // 17
        8'b01000010,  // 18
        8'b01000010,  // 19
        8'b01100010,  // 20
        8'b01000010,  // 21
        8'b01000010,  // 22
        8'b01000010,  // 23
        8'b01010010,  // 24 R2 offset 4 beyond range
        8'b01000010   // 25 R3 no trigger follows
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kill = 1'b0, hold = 1'b0;
    logic ante_lead = 1'b0, ante_end = 1'b0;
    logic cons_lead = 1'b0, cons_end = 1'b0;
    logic ok_chk, ok_cov;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    bit hk [HMAX];
    bit hh [HMAX];
    bit hal[HMAX];
    bit hae[HMAX];
    bit hcl[HMAX];
    bit hce[HMAX];

    always #(CLK_PERIOD/2) clk = ~clk;

    seqchk_implication #(
        .ANT_LO(AL), .ANT_HI(AH), .CON_GAP(GAP), .NON_OVERLAP(NOVL),
        .USE_HOLD(1'b1), .MODE(CHK_ASSERT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .kill(kill), .hold(hold),
        .ante_lead(ante_lead), .ante_end(ante_end),
        .cons_lead(cons_lead), .cons_end(cons_end), .prop_ok(ok_chk)
    );

    seqchk_implication #(
        .ANT_LO(AL), .ANT_HI(AH), .CON_GAP(GAP), .NON_OVERLAP(NOVL),
        .USE_HOLD(1'b1), .MODE(CHK_COVER)
    ) uut_cov (
        .clk(clk), .rst_n(rst_n), .kill(kill), .hold(hold),
        .ante_lead(ante_lead), .ante_end(ante_end),
        .cons_lead(cons_lead), .cons_end(cons_end), .prop_ok(ok_cov)
    );

    // ---------------- thread-level model over the input history --------
    function automatic bit nokill(int s, int u);
        for (int i = s; i <= u; i++) if (hk[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit ant_end(int u);
        if (u < 0 || !hae[u]) return 1'b0;
        for (int s = u - AH; s <= u - AL; s++)
            if (s >= 0 && hal[s] && nokill(s, u)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit trig(int u);
        if (u < 0) return 1'b0;
        if (NOVL) return ant_end(u - 1) && !hk[u];
        return ant_end(u);
    endfunction

    function automatic bit alive(int t, int u);
        int last;
        if (t < 0) return 1'b0;
        if (!(trig(t) && hcl[t])) return 1'b0;
        if (!nokill(t, u)) return 1'b0;
        last = (u - 1 > t) ? u - 1 : t;
        for (int i = t; i <= last; i++) if (!hh[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit mdl_match(int u);
        return hh[u] && hce[u] && alive(u - GAP, u);
    endfunction

    function automatic bit mdl_ok(int u);
        bit now_l, next_l;
        now_l = trig(u);
        next_l = 1'b0;
        for (int d = 0; d <= GAP; d++) if (alive(u - d, u)) now_l = 1'b1;
        for (int d = 0; d < GAP; d++) if (alive(u - d, u)) next_l = 1'b1;
        next_l = next_l && hh[u];
        return !(now_l && !next_l && !mdl_match(u));
    endfunction

    // ---------------- helpers -------------------------------------------
    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < HMAX; i++) begin
            hk[i] = 1'b0; hh[i] = 1'b0; hal[i] = 1'b0;
            hae[i] = 1'b0; hcl[i] = 1'b0; hce[i] = 1'b0;
        end
        cyc = 0;
    endtask

    task automatic step(input bit k, input bit h, input bit a1, input bit a2,
                        input bit c1, input bit c2, input string tag);
        @(negedge clk);
        kill = k; hold = h; ante_lead = a1; ante_end = a2;
        cons_lead = c1; cons_end = c2;
        hk[cyc] = k; hh[cyc] = h; hal[cyc] = a1;
        hae[cyc] = a2; hcl[cyc] = c1; hce[cyc] = c2;
        @(posedge clk);
        #1;
        check({tag, " check-mode verdict"}, ok_chk, mdl_ok(cyc));
        check({tag, " R9 cover verdict"}, ok_cov, mdl_match(cyc));
        cyc++;
    endtask

    // ---------------- stimulus -------------------------------------------
    initial begin
        clear_hist();
        repeat (3) @(negedge clk);
        check("R1 reset check-mode", ok_chk, 1'b1);
        check("R1 reset cover-mode", ok_cov, 1'b0);
        rst_n = 1'b1;

        // hand-worked table
        for (int r = 0; r < NVEC; r++) begin
            step(VEC[r][7], VEC[r][6], VEC[r][5], VEC[r][4], VEC[r][3], VEC[r][2],
                 "R2 R3 R4 R5 R7 R8 table");
            check($sformatf("table row %0d check-mode", r), ok_chk, VEC[r][1]);
            check($sformatf("table row %0d cover-mode", r), ok_cov, VEC[r][0]);
        end

        // random overlapping attempts with kill and hold drops
        for (int n = 0; n < NRAND; n++) begin
            step(($urandom % 16) == 0, ($urandom % 8) != 0, ($urandom % 3) == 0,
                 ($urandom % 2) == 1, ($urandom % 4) != 0, ($urandom % 2) == 1,
                 "R5 R6 R7 R8 random");
        end

        // reset in the middle of a pending trigger
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 pre-reset");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R1 pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        ante_lead = 1'b0; ante_end = 1'b0; cons_lead = 1'b0; cons_end = 1'b0;
        #1;
        check("R1 mid-run reset check-mode", ok_chk, 1'b1);
        check("R1 mid-run reset cover-mode", ok_cov, 1'b0);
        @(negedge clk);
        check("R1 reset held check-mode", ok_chk, 1'b1);
        rst_n = 1'b1;
        clear_hist();
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R1 after reset");
            check("R1 no attempt survives reset", ok_chk, 1'b1);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule